// File: doc/BRIEF.md
# DDR2 Power-Up Command Sequencer

This block walks a DDR2 SDRAM through its power-up and initialisation sequence once per reset. A single start pulse latches the memory geometry (column-bits code, row-bits code, address decode mode and data-bus width). The block then emits a fixed ordered list of fifteen commands on a command/address channel with a valid/ready handshake. Each command is held until the downstream command engine accepts it.

From the latched geometry the block derives the bit position where the bank-address field sits in the command address. It uses that position to select extended mode registers 2, 3 and 1. A long power-stabilisation interval follows the first NOP. It is counted in clock cycles by a down-counter whose length is a parameter. The DLL-reset mode register cycles and the OCD default/exit cycles are part of the fixed list. When the final dummy write has been accepted, the block raises a sticky done flag and enables periodic refresh.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset `cmd_valid`, `done` and `refresh_en` are low, and no command is presented until `start` is sampled high.
- R2: The bank field position is col_code + 9, plus row_code + 11 when `interleave` is low (sequential decode), plus 1 when `half_width` is high or 2 when it is low. The bank field occupies cmd_addr[pos+1:pos].
- R3: Commands are issued in this order, with op codes NOP=0, PRECHARGE_ALL=1, MRS=2, EMRS=3, REFRESH=4, NORMAL=5, WRITE=6: NOP, NOP, PRECHARGE_ALL, EMRS, EMRS, EMRS, MRS, PRECHARGE_ALL, REFRESH, REFRESH, MRS, EMRS, EMRS, NORMAL, WRITE.
- R4: The first MRS carries cmd_addr bit 8 set (DLL reset), the second MRS has it clear, and every other bit of both MRS addresses is zero. NOP, PRECHARGE_ALL, REFRESH, NORMAL and WRITE carry address zero.
- R5: The three leading EMRS commands carry bank values 2, 3 and 1 in that order, with all other address bits zero. The next EMRS carries bank 1 with cmd_addr[9:7]=3'b111 (OCD default), and the last carries bank 1 with cmd_addr[9:7]=3'b000 (OCD exit).
- R6: Between acceptance of the first NOP and presentation of the second NOP, `cmd_valid` is low for exactly PWR_WAIT_CYC clock cycles.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `cmd_addr` hold their values on the next cycle.
- R8: Geometry is latched when `start` is accepted. A `start` pulse during the sequence or after completion has no effect on the commands or on `done`.
- R9: `done` and `refresh_en` rise in the cycle after the WRITE is accepted and remain high, with `cmd_valid` low, until reset.
- R10: Apart from the power wait, each command after an accepted one is presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the sequence (honoured only when idle) |
| col_code | input | CODE_W | Column-bits geometry code |
| row_code | input | CODE_W | Row-bits geometry code |
| interleave | input | 1 | 1 = interleaved bank decode, 0 = sequential |
| half_width | input | 1 | 1 = half-width data bus |
| cmd_valid | output | 1 | Command presented |
| cmd_op | output | 4 | Command op code |
| cmd_addr | output | ADDR_W | Command address |
| cmd_ready | input | 1 | Downstream accepts the command |
| done | output | 1 | Sequence complete (sticky until reset) |
| refresh_en | output | 1 | Periodic refresh may run |

## Verification
The bench targets the geometry extremes: the smallest bank position (interleaved, column code 0, half width, position 10) and the largest (sequential, both codes 3, full width, position 28). A wrong offset formula would put the EMR select bits in the wrong place or drop the row term. Randomly stalled `cmd_ready` exposes a design that advances or changes address on an unaccepted command. A start pulse with different geometry mid-sequence catches a design that re-samples configuration or restarts. The power-wait gap is counted exactly, so an off-by-one in the down-counter shows as a gap one cycle long or short. Re-pulsing start after completion catches a design that clears done or replays the list.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [3:0] {
        CMD_NOP    = 4'd0,
        CMD_PALL   = 4'd1,
        CMD_MRS    = 4'd2,
        CMD_EMRS   = 4'd3,
        CMD_REF    = 4'd4,
        CMD_NORMAL = 4'd5,
        CMD_WRITE  = 4'd6
    } ddr_cmd_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_DONE  = 2'd3
    } seq_state_e;

    localparam int N_STEPS     = 15;
    localparam int DLL_RST_BIT = 8;
    localparam int OCD_LSB     = 7;
    localparam int COL_BASE    = 9;
    localparam int ROW_BASE    = 11;

endpackage

// File: rtl/ddr2_bank_offset.sv
module ddr2_bank_offset #(
    parameter int CODE_W = 2,
    parameter int OFF_W  = 5
) (
    input  logic [CODE_W-1:0] col_code,
    input  logic [CODE_W-1:0] row_code,
    input  logic              interleave,
    input  logic              half_width,
    output logic [OFF_W-1:0]  bank_pos
);
    import ddr2_init_pkg::*;

    int sum;

    always_comb begin
        sum = int'(col_code) + COL_BASE;
        if (!interleave) begin
            sum = sum + int'(row_code) + ROW_BASE;
        end
        sum = sum + (half_width ? 1 : 2);
        bank_pos = OFF_W'(sum);
    end

endmodule

// File: rtl/ddr2_step_decode.sv
module ddr2_step_decode #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int STEP_W = 4
) (
    input  logic [STEP_W-1:0] step,
    input  logic [OFF_W-1:0]  bank_pos,
    output logic [3:0]        op,
    output logic [ADDR_W-1:0] addr
);
    import ddr2_init_pkg::*;

    logic [ADDR_W-1:0] bank1_a;
    logic [ADDR_W-1:0] bank2_a;
    logic [ADDR_W-1:0] bank3_a;
    logic [ADDR_W-1:0] dll_a;
    logic [ADDR_W-1:0] ocd_a;

    always_comb begin
        bank1_a = ADDR_W'(1) << bank_pos;
        bank2_a = ADDR_W'(2) << bank_pos;
        bank3_a = ADDR_W'(3) << bank_pos;
        dll_a   = ADDR_W'(1) << DLL_RST_BIT;
        ocd_a   = ADDR_W'(7) << OCD_LSB;
        op      = CMD_NOP;
        addr    = '0;
        case (step)
            STEP_W'(0), STEP_W'(1): op = CMD_NOP;
            STEP_W'(2), STEP_W'(7): op = CMD_PALL;
            STEP_W'(3): begin op = CMD_EMRS; addr = bank2_a; end
            STEP_W'(4): begin op = CMD_EMRS; addr = bank3_a; end
            STEP_W'(5): begin op = CMD_EMRS; addr = bank1_a; end
            STEP_W'(6): begin op = CMD_MRS;  addr = dll_a;   end
            STEP_W'(8), STEP_W'(9): op = CMD_REF;
            STEP_W'(10): op = CMD_MRS;
            STEP_W'(11): begin op = CMD_EMRS; addr = bank1_a | ocd_a; end
            STEP_W'(12): begin op = CMD_EMRS; addr = bank1_a; end
            STEP_W'(13): op = CMD_NORMAL;
            STEP_W'(14): op = CMD_WRITE;
            default: op = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/ddr2_wait_timer.sv
module ddr2_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R6: once expired and not reloaded, the timer stays expired
    p_zero_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        zero && !load |=> zero);

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq #(
    parameter int ADDR_W       = 32,
    parameter int CODE_W       = 2,
    parameter int PWR_WAIT_CYC = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] col_code,
    input  logic [CODE_W-1:0] row_code,
    input  logic              interleave,
    input  logic              half_width,
    output logic              cmd_valid,
    output logic [3:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_ready,
    output logic              done,
    output logic              refresh_en
);
    import ddr2_init_pkg::*;

    localparam int OFF_W   = $clog2(ADDR_W);
    localparam int STEP_W  = $clog2(N_STEPS);
    localparam int WAIT_W  = $clog2(PWR_WAIT_CYC + 1);
    localparam int POS_MIN = COL_BASE + 1;
    localparam int POS_MAX = COL_BASE + ROW_BASE + 2 * ((1 << CODE_W) - 1) + 2;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);
    localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(PWR_WAIT_CYC - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [STEP_W-1:0] step;
        logic [OFF_W-1:0]  pos;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [OFF_W-1:0] pos_calc;
    logic             tmr_load;
    logic             tmr_zero;

    ddr2_bank_offset #(.CODE_W(CODE_W), .OFF_W(OFF_W)) u_offset (
        .col_code   (col_code),
        .row_code   (row_code),
        .interleave (interleave),
        .half_width (half_width),
        .bank_pos   (pos_calc)
    );

    ddr2_step_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .STEP_W(STEP_W)) u_decode (
        .step     (ctl_q.step),
        .bank_pos (ctl_q.pos),
        .op       (cmd_op),
        .addr     (cmd_addr)
    );

    ddr2_wait_timer #(.CNT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (WAIT_LOAD),
        .zero     (tmr_zero)
    );

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        case (ctl_q.state)
            S_IDLE: begin
                if (start) begin
                    ctl_d.pos   = pos_calc;
                    ctl_d.step  = '0;
                    ctl_d.state = S_ISSUE;
                end
            end
            S_ISSUE: begin
                if (cmd_ready) begin
                    if (ctl_q.step == '0) begin
                        tmr_load    = 1'b1;
                        ctl_d.state = S_WAIT;
                    end else if (ctl_q.step == LAST_STEP) begin
                        ctl_d.state = S_DONE;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.step = ctl_q.step + 1'b1;
                    end
                end
            end
            S_WAIT: begin
                if (tmr_zero) begin
                    ctl_d.step  = STEP_W'(1);
                    ctl_d.state = S_ISSUE;
                end
            end
            default: ctl_d = ctl_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: S_IDLE, step: '0, pos: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmd_valid  = (ctl_q.state == S_ISSUE);
    assign done       = ctl_q.done;
    assign refresh_en = (ctl_q.state == S_DONE);

    // R7: a stalled command keeps its valid, op and address
    p_hold_while_stalled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr));

    // R9: done is sticky
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R9: nothing is issued after completion, and refresh is enabled
    p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid && refresh_en);

    // R9: completion follows acceptance of the dummy write
    p_done_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(cmd_valid && cmd_ready && cmd_op == CMD_WRITE));

    // R2: latched bank position lies within the range the geometry allows
    p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (int'(ctl_q.pos) >= POS_MIN) && (int'(ctl_q.pos) <= POS_MAX));

    // R1: nothing is presented before a start has been seen
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid && !done && !start && ctl_q.state == S_IDLE |=> !cmd_valid);

endmodule

// File: tb/ddr2_init_seq_bench.sv
`timescale 1ns/1ps
module ddr2_init_seq_bench;
    localparam int ADDR_W = 32;
    localparam int CODE_W = 2;
    localparam int PWR    = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CODE_W-1:0] col_code = '0;
    logic [CODE_W-1:0] row_code = '0;
    logic              interleave = 1'b0;
    logic              half_width = 1'b0;
    logic              cmd_valid;
    logic [3:0]        cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic              cmd_ready = 1'b0;
    logic              done;
    logic              refresh_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    ddr2_init_seq #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .PWR_WAIT_CYC(PWR)) u_ddr2_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .col_code(col_code),
        .row_code(row_code), .interleave(interleave), .half_width(half_width),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_ready(cmd_ready), .done(done), .refresh_en(refresh_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int exp_pos(int cc, int rc, bit il, bit hw);
        return cc + 9 + (il ? 0 : rc + 11) + (hw ? 1 : 2);
    endfunction

    function automatic logic [3:0] exp_op(int i);
        case (i)
            0, 1:           return 4'd0;
            2, 7:           return 4'd1;
            3, 4, 5, 11, 12: return 4'd3;
            6, 10:          return 4'd2;
            8, 9:           return 4'd4;
            13:             return 4'd5;
            default:        return 4'd6;
        endcase
    endfunction

    function automatic logic [31:0] exp_addr(int i, int pos);
        case (i)
            3:       return 32'd2 << pos;
            4:       return 32'd3 << pos;
            5, 12:   return 32'd1 << pos;
            6:       return 32'd1 << 8;
            11:      return (32'd1 << pos) | (32'd7 << 7);
            default: return 32'd0;
        endcase
    endfunction

    task automatic run_seq(input int cc, input int rc, input bit il, input bit hw, input int ready_pct);
        int pos;
        int gap;
        logic [3:0]  h_op;
        logic [31:0] h_addr;
        bit          got;
        pos = exp_pos(cc, rc, il, hw);
        rst_n = 1'b0;
        start = 1'b0;
        cmd_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 valid after reset", 32'(cmd_valid), 0);
        chk("R1 done after reset", 32'(done), 0);
        chk("R1 refresh after reset", 32'(refresh_en), 0);
        repeat (4) @(negedge clk);
        #1 chk("R1 idle without start", 32'(cmd_valid), 0);
        @(negedge clk);
        col_code = CODE_W'(cc); row_code = CODE_W'(rc);
        interleave = il; half_width = hw; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        col_code = CODE_W'($urandom); row_code = CODE_W'($urandom);
        interleave = 1'($urandom); half_width = 1'($urandom);
        for (int i = 0; i < 15; i++) begin
            #1;
            gap = 0;
            while (!cmd_valid && gap < 1000) begin
                @(negedge clk); #1;
                gap++;
            end
            if (i == 1) chk("R6 power wait gap", 32'(gap), 32'(PWR));
            else if (i > 1) chk("R10 back-to-back gap", 32'(gap), 0);
            chk($sformatf("R3 op of step %0d", i), 32'(cmd_op), 32'(exp_op(i)));
            if (i == 3 || i == 4 || i == 5 || i == 11 || i == 12)
                chk($sformatf("R5 R2 emrs addr step %0d", i), cmd_addr, exp_addr(i, pos));
            else
                chk($sformatf("R4 addr step %0d", i), cmd_addr, exp_addr(i, pos));
            got = 1'b0;
            while (!got) begin
                cmd_ready = (($urandom % 100) < 32'(ready_pct));
                if (i == 5) begin
                    start = 1'b1;
                    col_code = CODE_W'($urandom); interleave = ~il; half_width = ~hw;
                end
                h_op = cmd_op; h_addr = cmd_addr;
                @(negedge clk);
                start = 1'b0;
                if (cmd_ready) begin
                    got = 1'b1;
                    cmd_ready = 1'b0;
                end else begin
                    #1;
                    chk("R7 valid held", 32'(cmd_valid), 1);
                    chk("R7 op held", 32'(cmd_op), 32'(h_op));
                    chk("R7 addr held", cmd_addr, h_addr);
                end
            end
        end
        #1;
        chk("R9 done after write", 32'(done), 1);
        chk("R9 refresh after write", 32'(refresh_en), 1);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); #1;
            chk("R8 start after done ignored", 32'(cmd_valid), 0);
            chk("R9 done sticky", 32'(done), 1);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_2d2d));
        run_seq(3, 3, 1'b0, 1'b0, 100);
        run_seq(0, 0, 1'b1, 1'b1, 100);
        run_seq(0, 0, 1'b0, 1'b1, 40);
        run_seq(3, 0, 1'b1, 1'b0, 60);
        for (int r = 0; r < 6; r++) begin
            run_seq(int'($urandom % 4), int'($urandom % 4), 1'($urandom), 1'($urandom),
                    30 + int'($urandom % 70));
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule